// File: doc/BRIEF.md
# Pixel Hit Edge Timestamp Capture

This block is the digital tail of one pixel in a triggerless pixel matrix. A discriminator output from the analog front end is brought into the clock domain through a two-flip-flop synchronizer. Edge detection follows. On the rising edge of a hit pulse the block samples a shared, Gray-coded time bus. It samples the same bus again on the falling edge. The two samples together give the arrival time and the time-over-threshold of the hit.

The two stamps fill a 16-bit storage word. The leading stamp is in the upper byte and the trailing stamp is in the lower byte. Once the trailing stamp is stored, a pending flag rises and asks the column readout for service. No trigger is involved. While the flag is set the pixel holds its word and ignores all new pulses.

In the cycle where the column grants the pixel, it drives a 22-bit word onto the shared column bus and raises its output enable. The word is made of the two stamps and the pixel's fixed 6-bit address. At the next clock the pixel clears itself and is ready for the next hit.

Top module: `pix_edge_stamp`

## Requirements
- R1: After synchronous active-low reset, hit_pending, col_oe and col_data are all 0.
- R2: The leading stamp is the ts_bus value present at the third rising clock edge after disc_in goes high. That edge is two synchronizer stages plus one capture register after the change. The stamp appears in col_data[21:14].
- R3: The trailing stamp is the ts_bus value present at the third rising clock edge after disc_in goes low. It appears in col_data[13:6]. col_data[5:0] carries the PIX_ADDR parameter.
- R4: hit_pending stays 0 while the pulse is still high. It becomes 1 at the same edge that captures the trailing stamp.
- R5: While hit_pending is 1 and grant is 0, discriminator pulses are ignored. The stored word and the pending flag stay unchanged.
- R6: col_oe is 1 only in a cycle where grant and hit_pending are both 1. In every other cycle col_oe is 0 and col_data is all zeros.
- R7: A cycle with grant high while a hit is pending clears hit_pending at the following clock edge. A later pulse is then captured fresh.
- R8: A grant while no hit is pending has no effect. In particular, a hit whose leading edge is already stored but whose trailing edge is not yet seen is kept and completes normally.
- R9: A discriminator pulse only one clock cycle long still yields a complete hit. Its leading and trailing stamps are taken on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc_in | input | 1 | Asynchronous discriminator output |
| ts_bus | input | 8 | Shared Gray-coded time stamp |
| grant | input | 1 | Column readout grant for this pixel |
| hit_pending | output | 1 | Complete hit waiting for readout |
| col_oe | output | 1 | Output enable for the column bus |
| col_data | output | 22 | {leading stamp, trailing stamp, pixel address} |

## Verification
Two situations are the hardest to reach from the ports. One is a grant that arrives after the leading stamp is stored but before the falling edge. The other is a second pulse that comes while an earlier hit is still waiting. To reach either one, the bench must know the three-cycle capture latency exactly. It places the grant in the gap between the two captures, and it sends a full extra pulse with different bus values before reading. The readout must then show the original stamps. A single-cycle pulse is also sent to prove that both captures can take place on consecutive edges.

// File: rtl/pix_stamp_pkg.sv
// Package: shared types for the pixel edge time-stamp logic.
// Assumes nothing beyond a single clock domain for all users.
package pix_stamp_pkg;
    // Capture sequencing: waiting for a hit, leading edge stored, word complete.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PEND  = 2'd2
    } cap_state_t;
endpackage

// File: rtl/pix_disc_sync.sv
// Module: brings the asynchronous discriminator level into the clock domain
// through STAGES flip-flops, then flags one-cycle rise and fall events.
// Assumes disc_in may change at any time relative to clk.
module pix_disc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disc_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_q;

    // Synchronizer chain plus one extra stage used to detect edges.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], disc_in};
    end

    // Edge events from the last synchronized stage against its delayed copy.
    always_comb begin
        level = pipe_q[STAGES-1];
        rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        fall  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/pix_stamp_store.sv
// Module: stores the leading and trailing time stamps of one hit. It raises
// the pending flag once both stamps are held and clears on a granted read.
// Assumes rise and fall are single-cycle events that never occur together.
module pix_stamp_store
    import pix_stamp_pkg::*;
#(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic            fall,
    input  logic [TS_W-1:0] ts_bus,
    input  logic            grant,
    output logic            pending,
    output logic [TS_W-1:0] lead_ts,
    output logic [TS_W-1:0] trail_ts
);
    cap_state_t state_q;

    // Capture sequencing and stamp registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lead_ts  <= '0;
            trail_ts <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (rise) begin
                    lead_ts <= ts_bus;
                    state_q <= ST_ARMED;
                end
                ST_ARMED: if (fall) begin
                    trail_ts <= ts_bus;
                    state_q  <= ST_PEND;
                end
                ST_PEND: if (grant) begin
                    lead_ts  <= '0;
                    trail_ts <= '0;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pending flag decoded from the sequencing state.
    always_comb pending = (state_q == ST_PEND);
endmodule

// File: rtl/pix_bus_drive.sv
// Module: places the stored hit word on the shared column bus only while
// granted with a hit pending. It drives zeros and a low enable otherwise.
// Assumes the column combines pixel outputs qualified by their enables.
module pix_bus_drive #(
    parameter int TS_W   = 8,
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] PIX_ADDR = '0,
    localparam int BUS_W = 2*TS_W + ADDR_W
) (
    input  logic             grant,
    input  logic             pending,
    input  logic [TS_W-1:0]  lead_ts,
    input  logic [TS_W-1:0]  trail_ts,
    output logic             col_oe,
    output logic [BUS_W-1:0] col_data
);
    // Gate the word onto the bus for the granted cycle only.
    always_comb begin
        col_oe   = grant & pending;
        col_data = col_oe ? {lead_ts, trail_ts, PIX_ADDR} : '0;
    end
endmodule

// File: rtl/pix_edge_stamp.sv
// Module: top of the per-pixel digital logic. It synchronizes the
// discriminator and stores the edge stamps, then exports the hit on grant.
// Assumes ts_bus is stable around each clock edge (Gray-coded upstream).
module pix_edge_stamp #(
    parameter int TS_W   = 8,
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] PIX_ADDR = '0,
    localparam int BUS_W = 2*TS_W + ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_in,
    input  logic [TS_W-1:0]  ts_bus,
    input  logic             grant,
    output logic             hit_pending,
    output logic             col_oe,
    output logic [BUS_W-1:0] col_data
);
    logic            disc_s, disc_rise, disc_fall;
    logic [TS_W-1:0] lead_ts, trail_ts;
    logic [2*TS_W-1:0] stamp_word;

    pix_disc_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .disc_in(disc_in),
        .level(disc_s), .rise(disc_rise), .fall(disc_fall)
    );

    pix_stamp_store #(.TS_W(TS_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rise(disc_rise), .fall(disc_fall),
        .ts_bus(ts_bus), .grant(grant), .pending(hit_pending),
        .lead_ts(lead_ts), .trail_ts(trail_ts)
    );

    pix_bus_drive #(.TS_W(TS_W), .ADDR_W(ADDR_W), .PIX_ADDR(PIX_ADDR)) u_drive (
        .grant(grant), .pending(hit_pending), .lead_ts(lead_ts),
        .trail_ts(trail_ts), .col_oe(col_oe), .col_data(col_data)
    );

    // Stored word, kept visible for the bound checker.
    always_comb stamp_word = {lead_ts, trail_ts};
endmodule

// File: rtl/pix_edge_stamp_chk.sv
// Module: property checker for pix_edge_stamp, attached by bind.
// Assumes the same clock and synchronous reset as the checked block.
module pix_edge_stamp_chk #(
    parameter int TS_W   = 8,
    parameter int ADDR_W = 6,
    localparam int BUS_W = 2*TS_W + ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant,
    input logic              disc_s,
    input logic              hit_pending,
    input logic              col_oe,
    input logic [BUS_W-1:0]  col_data,
    input logic [2*TS_W-1:0] stamp_word
);
    // R6: without a grant the bus is released and quiet.
    a_r6_release_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (!col_oe && col_data == '0));

    // R6: the enable never rises without a pending hit.
    a_r6_oe_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        col_oe |-> hit_pending);

    // R7: a granted pending hit is cleared at the next edge.
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pending && grant) |=> !hit_pending);

    // R5: a waiting hit keeps its stamps until it is read.
    a_r5_hold_stamps: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pending && !grant) |=> (hit_pending && $stable(stamp_word)));

    // R4: pending appears only once the synchronized level has dropped.
    a_r4_pending_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_pending) |-> !$past(disc_s));
endmodule

bind pix_edge_stamp pix_edge_stamp_chk #(.TS_W(TS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .disc_s(disc_s),
    .hit_pending(hit_pending), .col_oe(col_oe), .col_data(col_data),
    .stamp_word(stamp_word)
);

// File: tb/pix_edge_stamp_tb.sv
module pix_edge_stamp_tb;
    localparam logic [5:0] ADDR = 6'h2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disc_in = 1'b0;
    logic [7:0]  ts_bus = 8'h00;
    logic        grant = 1'b0;
    logic        hit_pending, col_oe;
    logic [21:0] col_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pix_edge_stamp #(.TS_W(8), .ADDR_W(6), .PIX_ADDR(ADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .ts_bus(ts_bus),
        .grant(grant), .hit_pending(hit_pending), .col_oe(col_oe),
        .col_data(col_data)
    );

    always #5 clk = ~clk;

    // {leading stamp, trailing stamp, cycles the pulse stays high after capture}
    localparam logic [23:0] VEC [6] = '{
        24'h01_03_02, 24'h5A_A5_00, 24'hFF_00_05,
        24'h80_81_01, 24'h3C_C3_07, 24'h12_34_03
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rise_at(input logic [7:0] ts);
        @(negedge clk); ts_bus = ts; disc_in = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic fall_at(input logic [7:0] ts);
        @(negedge clk); ts_bus = ts; disc_in = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic read_hit(input string tag, input logic [21:0] exp);
        @(negedge clk); grant = 1'b1; #1;
        chk({tag, " oe"}, {31'd0, col_oe}, 32'd1);
        chk({tag, " data"}, {10'd0, col_data}, {10'd0, exp});
        @(negedge clk); grant = 1'b0; #1;
        chk({tag, " cleared"}, {31'd0, hit_pending}, 32'd0);
        chk({tag, " released"}, {9'd0, col_oe, col_data}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {9'd0, hit_pending, col_oe, col_data[19:0]}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R4: table of hits
        foreach (VEC[i]) begin
            rise_at(VEC[i][23:16]);
            @(negedge clk); ts_bus = ~VEC[i][23:16];
            repeat (int'(VEC[i][7:0])) @(negedge clk);
            #1 chk("R4 no pending while high", {31'd0, hit_pending}, 32'd0);
            fall_at(VEC[i][15:8]);
            @(negedge clk); ts_bus = 8'h00; #1;
            chk("R4 pending after trailing", {31'd0, hit_pending}, 32'd1);
            chk("R6 no oe without grant", {31'd0, col_oe}, 32'd0);
            read_hit("R2 R3 table", {VEC[i][23:16], VEC[i][15:8], ADDR});
        end

        // R6 R8: grant with nothing stored
        @(negedge clk); grant = 1'b1; #1;
        chk("R8 idle grant oe", {31'd0, col_oe}, 32'd0);
        chk("R6 idle grant data", {10'd0, col_data}, 32'd0);
        @(negedge clk); grant = 1'b0;

        // R8: grant between leading and trailing capture
        rise_at(8'h6E);
        @(negedge clk); grant = 1'b1; ts_bus = 8'h11; #1;
        chk("R8 armed grant oe", {31'd0, col_oe}, 32'd0);
        @(negedge clk); grant = 1'b0; #1;
        chk("R8 armed grant pending", {31'd0, hit_pending}, 32'd0);
        fall_at(8'h9D);
        @(negedge clk);
        read_hit("R8 armed hit kept", {8'h6E, 8'h9D, ADDR});

        // R5: pulse while pending is ignored
        rise_at(8'h21);
        fall_at(8'h43);
        rise_at(8'hAA);
        @(negedge clk); ts_bus = 8'hBB;
        fall_at(8'hCC);
        repeat (3) @(negedge clk);
        #1 chk("R5 still pending", {31'd0, hit_pending}, 32'd1);
        read_hit("R5 old word", {8'h21, 8'h43, ADDR});
        repeat (4) @(negedge clk);
        #1 chk("R5 ignored pulse left no hit", {31'd0, hit_pending}, 32'd0);

        // R7: a fresh hit after read
        rise_at(8'h70);
        fall_at(8'h07);
        @(negedge clk);
        read_hit("R7 fresh hit", {8'h70, 8'h07, ADDR});

        // R9: one-cycle pulse, ts held constant
        @(negedge clk); ts_bus = 8'h5F; disc_in = 1'b1;
        @(negedge clk); disc_in = 1'b0;
        repeat (4) @(negedge clk);
        #1 chk("R9 short pulse pending", {31'd0, hit_pending}, 32'd1);
        read_hit("R9 short pulse", {8'h5F, 8'h5F, ADDR});

        // R1: reset in the middle of a hit
        rise_at(8'h99);
        @(negedge clk); rst_n = 1'b0; disc_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        #1 chk("R1 reset drops partial hit", {31'd0, hit_pending}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule